// File: doc/BRIEF.md
# Byte-wide MAC to double-data-rate nibble PHY adapter

This block sits between a MAC that works on whole bytes and a PHY link with four data wires and one control wire per direction, where both halves of every clock period carry information. On the way out it takes a byte with its enable and error flags and puts it onto the nibble bus. In gigabit mode a whole byte goes out in one clock period. In the two slower modes each byte is spread over two clock periods. On the way in it captures the nibble bus on both clock edges, rebuilds bytes, and hands them to the MAC with valid and error flags.

The transmit side runs on `tx_clk`, which is forwarded to the PHY unchanged. The receive side runs on the clock that the PHY supplies. A two-bit `speed` input selects the mode. Each direction picks up a new mode only between frames. Delay alignment of the clocks, clock generation and the management bus are handled elsewhere.

Top module: `gmii_rgmii_bridge`

## Requirements
- R1: In gigabit mode, a byte captured at a rising edge of `tx_clk` is driven in the following clock period: `mac_txd[3:0]` while the clock is high and `mac_txd[7:4]` while it is low.
- R2: While a byte is being sent, `phy_tx_ctl` is high during the high half of the period and equals enable XOR error during the low half.
- R3: When `mac_tx_en` is low at a capturing edge, `phy_txd` is 0 and `phy_tx_ctl` is low for both halves of the following period, whatever `mac_tx_err` and `mac_txd` hold.
- R4: In the two slower modes, the MAC holds each byte for two cycles. The first enabled cycle of a frame sends the low nibble and the next cycle sends the high nibble, alternating from there. The same nibble is driven during both halves of a period.
- R5: The `speed` encoding is: 2'b10 selects gigabit, 2'b01 selects 100 Mb/s and 2'b00 selects 10 Mb/s. The value 2'b11 behaves like the slower modes. The 10 and 100 modes behave identically per clock.
- R6: Transmit reloads the mode only at rising edges where `mac_tx_en` is low. Receive reloads it only when it processes a rising-edge control sample that is low. A `speed` change during a frame therefore leaves that frame unaffected.
- R7: In gigabit mode, the nibbles captured at the rising edge and then the falling edge of receive cycle k appear as `mac_rxd` = {falling nibble, rising nibble} after the next rising edge (k+1). `mac_rx_valid` equals the rising control sample and `mac_rx_err` equals rising XOR falling control.
- R8: Whenever `mac_rx_valid` is low, `mac_rxd` is 0 and `mac_rx_err` is low. Samples whose rising control bit is low produce no output, even if the falling control bit is high.
- R9: In the slower modes, the receiver pairs rising-edge nibbles starting with the first cycle whose control is high, taking the low nibble first. It raises `mac_rx_valid` for one cycle after the rising edge that follows the cycle of the high nibble. `mac_rx_err` is the OR of the two cycles' control XOR. A nibble left unpaired when control drops is discarded.
- R10: `phy_tx_clk` follows `tx_clk` level for level.
- R11: While `rst_n` is low, `phy_txd`, `phy_tx_ctl`, `mac_rx_valid`, `mac_rx_err` and `mac_rxd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both directions |
| speed | input | 2 | Mode select: 10 gigabit, 01 100 Mb/s, 00 10 Mb/s, 11 as slower modes |
| tx_clk | input | 1 | Transmit clock at link rate (125, 25 or 2.5 MHz) |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_tx_err | input | 1 | MAC transmit error |
| mac_txd | input | 8 | MAC transmit byte |
| phy_tx_clk | output | 1 | Clock forwarded to the PHY |
| phy_txd | output | 4 | Double-data-rate transmit nibble |
| phy_tx_ctl | output | 1 | Double-data-rate transmit control |
| phy_rx_clk | input | 1 | Receive clock from the PHY |
| phy_rxd | input | 4 | Double-data-rate receive nibble |
| phy_rx_ctl | input | 1 | Double-data-rate receive control |
| mac_rx_valid | output | 1 | Rebuilt byte valid |
| mac_rx_err | output | 1 | Rebuilt byte error |
| mac_rxd | output | 8 | Rebuilt byte |

## Verification
A transmit byte captured at rising edge k is visible on the nibble bus during period k. The bench samples it a quarter period into the high half and again a quarter period into the low half, so it checks each half away from both edges. On receive, a gigabit byte sampled in cycle k must appear at cycle k+1. A slower-mode byte must appear one cycle after the cycle that carried its high nibble. The bench numbers every receive cycle, records the number at which it drove each rising-edge sample and at which each valid strobe appeared, and compares both the bytes and the cycle numbers against a list it builds from R7 and R9.

// File: rtl/gmii_rgmii_bridge.sv
module gmii_rgmii_bridge (
  input  logic       rst_n,
  input  logic [1:0] speed,
  input  logic       tx_clk,
  input  logic       mac_tx_en,
  input  logic       mac_tx_err,
  input  logic [7:0] mac_txd,
  output logic       phy_tx_clk,
  output logic [3:0] phy_txd,
  output logic       phy_tx_ctl,
  input  logic       phy_rx_clk,
  input  logic [3:0] phy_rxd,
  input  logic       phy_rx_ctl,
  output logic       mac_rx_valid,
  output logic       mac_rx_err,
  output logic [7:0] mac_rxd
);

  logic sel_gig;
  assign sel_gig = speed[1] & ~speed[0];

  // transmit: capture at rising edge, level-selected halves
  logic       tx_gig, tx_ph;
  logic [3:0] tq_r, tq_f, tx_nib;
  logic       tc_r, tc_f;

  assign tx_nib = tx_ph ? mac_txd[7:4] : mac_txd[3:0];

  always_ff @(posedge tx_clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_gig <= 1'b1;
      tx_ph  <= 1'b0;
      tq_r   <= '0;
      tq_f   <= '0;
      tc_r   <= 1'b0;
      tc_f   <= 1'b0;
    end else begin
      tc_r <= mac_tx_en;
      tc_f <= mac_tx_en & ~mac_tx_err;
      if (!mac_tx_en) begin
        tq_r   <= '0;
        tq_f   <= '0;
        tx_ph  <= 1'b0;
        tx_gig <= sel_gig;
      end else if (tx_gig) begin
        tq_r <= mac_txd[3:0];
        tq_f <= mac_txd[7:4];
      end else begin
        tq_r  <= tx_nib;
        tq_f  <= tx_nib;
        tx_ph <= ~tx_ph;
      end
    end
  end

  assign phy_tx_clk = tx_clk;
  assign phy_txd    = tx_clk ? tq_r : tq_f;
  assign phy_tx_ctl = tx_clk ? tc_r : tc_f;

  // receive: both-edge capture, assembly at the next rising edge
  logic [3:0] rs_d, fs_d, lo_nib;
  logic       rs_c, fs_c, lo_err, rx_gig, rx_ph, cyc_err;

  assign cyc_err = rs_c ^ fs_c;

  always_ff @(negedge phy_rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_d <= '0;
      fs_c <= 1'b0;
    end else begin
      fs_d <= phy_rxd;
      fs_c <= phy_rx_ctl;
    end
  end

  always_ff @(posedge phy_rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_d         <= '0;
      rs_c         <= 1'b0;
      lo_nib       <= '0;
      lo_err       <= 1'b0;
      rx_gig       <= 1'b1;
      rx_ph        <= 1'b0;
      mac_rx_valid <= 1'b0;
      mac_rx_err   <= 1'b0;
      mac_rxd      <= '0;
    end else begin
      rs_d         <= phy_rxd;
      rs_c         <= phy_rx_ctl;
      mac_rx_valid <= 1'b0;
      mac_rx_err   <= 1'b0;
      mac_rxd      <= '0;
      if (!rs_c) begin
        rx_ph  <= 1'b0;
        rx_gig <= sel_gig;
      end else if (rx_gig) begin
        mac_rx_valid <= 1'b1;
        mac_rx_err   <= cyc_err;
        mac_rxd      <= {fs_d, rs_d};
      end else if (!rx_ph) begin
        lo_nib <= rs_d;
        lo_err <= cyc_err;
        rx_ph  <= 1'b1;
      end else begin
        mac_rx_valid <= 1'b1;
        mac_rx_err   <= lo_err | cyc_err;
        mac_rxd      <= {rs_d, lo_nib};
        rx_ph        <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/gmii_rgmii_bridge_sva.sv
module gmii_rgmii_bridge_sva (
  input logic       rst_n,
  input logic       tx_clk,
  input logic       mac_tx_en,
  input logic       mac_tx_err,
  input logic [3:0] phy_txd,
  input logic       phy_tx_ctl,
  input logic       phy_rx_clk,
  input logic       mac_rx_valid,
  input logic       mac_rx_err,
  input logic [7:0] mac_rxd
);

  // both halves of the period after an idle capture are quiet
  assert_tx_idle_quiet_R3: assert property (@(negedge tx_clk) disable iff (!rst_n)
    !mac_tx_en |-> (phy_txd == 4'h0 && !phy_tx_ctl));

  // a clean byte keeps control high in both halves
  assert_tx_ctl_clean_R2: assert property (@(negedge tx_clk) disable iff (!rst_n)
    (mac_tx_en && !mac_tx_err) |-> phy_tx_ctl);

  assert_rx_idle_zero_R8: assert property (@(posedge phy_rx_clk) disable iff (!rst_n)
    !mac_rx_valid |-> (mac_rxd == 8'h00));

  assert_rx_err_needs_valid_R8: assert property (@(posedge phy_rx_clk) disable iff (!rst_n)
    mac_rx_err |-> mac_rx_valid);

endmodule

bind gmii_rgmii_bridge gmii_rgmii_bridge_sva i_sva (
  .rst_n(rst_n), .tx_clk(tx_clk), .mac_tx_en(mac_tx_en), .mac_tx_err(mac_tx_err),
  .phy_txd(phy_txd), .phy_tx_ctl(phy_tx_ctl), .phy_rx_clk(phy_rx_clk),
  .mac_rx_valid(mac_rx_valid), .mac_rx_err(mac_rx_err), .mac_rxd(mac_rxd)
);

// File: tb/test_gmii_rgmii_bridge.sv
module test_gmii_rgmii_bridge;
  localparam int CLK_PERIOD = 8;
  localparam int Q = CLK_PERIOD / 4;
  localparam int LOGN = 1024;

  logic       tx_clk = 1'b0;
  logic       rx_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed = 2'b10;
  logic       mac_tx_en = 1'b0;
  logic       mac_tx_err = 1'b0;
  logic [7:0] mac_txd = 8'h00;
  logic       phy_tx_clk;
  logic [3:0] phy_txd;
  logic       phy_tx_ctl;
  logic [3:0] phy_rxd = 4'h0;
  logic       phy_rx_ctl = 1'b0;
  logic       mac_rx_valid;
  logic       mac_rx_err;
  logic [7:0] mac_rxd;

  int n_tests = 0;
  int n_fail = 0;
  int rxcyc = 0;
  bit m_gig = 1'b1;
  bit m_ph = 1'b0;
  bit done = 1'b0;
  logic [8:0] got_v [LOGN];
  int         got_c [LOGN];
  int         got_n = 0;
  logic [8:0] exp_v [LOGN];
  int         exp_c [LOGN];
  string      exp_t [LOGN];
  int         exp_n = 0;

  gmii_rgmii_bridge i_gmii_rgmii_bridge (
    .rst_n(rst_n), .speed(speed), .tx_clk(tx_clk),
    .mac_tx_en(mac_tx_en), .mac_tx_err(mac_tx_err), .mac_txd(mac_txd),
    .phy_tx_clk(phy_tx_clk), .phy_txd(phy_txd), .phy_tx_ctl(phy_tx_ctl),
    .phy_rx_clk(rx_clk), .phy_rxd(phy_rxd), .phy_rx_ctl(phy_rx_ctl),
    .mac_rx_valid(mac_rx_valid), .mac_rx_err(mac_rx_err), .mac_rxd(mac_rxd)
  );

  always #(CLK_PERIOD / 2) tx_clk = ~tx_clk;
  always #(CLK_PERIOD / 2) rx_clk = ~rx_clk;
  always @(posedge rx_clk) rxcyc <= rxcyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // one transmit period; expected halves from R1..R4, model of R6 latching
  task automatic tx_step(input bit en, input bit er, input logic [7:0] d, input string tag);
    logic [3:0] rn, fn;
    bit rc, fc;
    mac_tx_en = en;
    mac_tx_err = er;
    mac_txd = d;
    rc = en;
    fc = en & ~er;
    if (!en) begin
      rn = 4'h0;
      fn = 4'h0;
    end else if (m_gig) begin
      rn = d[3:0];
      fn = d[7:4];
    end else begin
      rn = m_ph ? d[7:4] : d[3:0];
      fn = rn;
    end
    if (!en) begin
      m_ph = 1'b0;
      m_gig = (speed == 2'b10);
    end else if (!m_gig) begin
      m_ph = ~m_ph;
    end
    @(posedge tx_clk); #Q;
    check({phy_tx_clk, phy_tx_ctl, phy_txd} == {1'b1, rc, rn}, {tag, " R10 high half"},
          int'({phy_tx_clk, phy_tx_ctl, phy_txd}), int'({1'b1, rc, rn}));
    @(negedge tx_clk); #Q;
    check({phy_tx_clk, phy_tx_ctl, phy_txd} == {1'b0, fc, fn}, {tag, " R2 low half"},
          int'({phy_tx_clk, phy_tx_ctl, phy_txd}), int'({1'b0, fc, fn}));
  endtask

  task automatic rx_cycle(input logic [3:0] rn, input bit rc, input logic [3:0] fn,
                          input bit fc, output int k);
    @(negedge rx_clk); #Q;
    phy_rxd = rn;
    phy_rx_ctl = rc;
    @(posedge rx_clk); #Q;
    k = rxcyc;
    phy_rxd = fn;
    phy_rx_ctl = fc;
  endtask

  task automatic expect_byte(input logic [8:0] v, input int c, input string t);
    exp_v[exp_n] = v;
    exp_c[exp_n] = c;
    exp_t[exp_n] = t;
    exp_n++;
  endtask

  task automatic rx_gbyte(input logic [7:0] d, input bit er, input string t);
    int k;
    rx_cycle(d[3:0], 1'b1, d[7:4], !er, k);
    expect_byte({er, d}, k + 1, t);
  endtask

  task automatic rx_nbyte(input logic [7:0] d, input bit e1, input bit e2, input string t);
    int k;
    rx_cycle(d[3:0], 1'b1, d[3:0], !e1, k);
    rx_cycle(d[7:4], 1'b1, d[7:4], !e2, k);
    expect_byte({e1 | e2, d}, k + 1, t);
  endtask

  task automatic rx_idle(input int n);
    int k;
    for (int j = 0; j < n; j++) rx_cycle(4'h0, 1'b0, 4'h0, 1'b0, k);
  endtask

  always @(posedge rx_clk) begin
    #Q;
    if (rst_n && mac_rx_valid) begin
      if (got_n < LOGN) begin
        got_v[got_n] = {mac_rx_err, mac_rxd};
        got_c[got_n] = rxcyc;
      end
      got_n++;
    end else if (rst_n && !done) begin
      check(mac_rxd == 8'h00 && !mac_rx_err, "R8 idle output",
            int'({mac_rx_err, mac_rxd}), 0);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int k;
    #(CLK_PERIOD * 3 + 1);
    check({phy_tx_ctl, phy_txd, mac_rx_valid, mac_rx_err, mac_rxd} == 15'd0, "R11 reset",
          int'({phy_tx_ctl, phy_txd, mac_rx_valid, mac_rx_err, mac_rxd}), 0);
    @(negedge tx_clk); #Q;
    rst_n = 1'b1;

    tx_step(1'b0, 1'b0, 8'h00, "R3");
    tx_step(1'b0, 1'b0, 8'h00, "R3");
    for (int i = 0; i < 256; i++) tx_step(1'b1, i[0] ^ i[5], 8'(i), "R1");
    for (int i = 0; i < 16; i++) tx_step(1'b0, i[1], 8'(i * 37 + 5), "R3");
    tx_step(1'b1, 1'b0, 8'hA5, "R6");
    speed = 2'b01;
    tx_step(1'b1, 1'b1, 8'h3C, "R6");
    tx_step(1'b1, 1'b0, 8'h5A, "R6");
    tx_step(1'b0, 1'b0, 8'h00, "R6");
    for (int i = 0; i < 256; i++) begin
      tx_step(1'b1, i[2], 8'(i), "R4");
      tx_step(1'b1, i[2], 8'(i), "R4");
    end
    tx_step(1'b0, 1'b0, 8'h00, "R4");
    tx_step(1'b1, 1'b0, 8'hC3, "R6");
    speed = 2'b10;
    tx_step(1'b1, 1'b0, 8'hC3, "R6");
    tx_step(1'b1, 1'b1, 8'h96, "R6");
    tx_step(1'b1, 1'b1, 8'h96, "R6");
    tx_step(1'b0, 1'b0, 8'h00, "R6");
    speed = 2'b00;
    tx_step(1'b0, 1'b0, 8'h00, "R5");
    for (int i = 0; i < 8; i++) begin
      tx_step(1'b1, 1'b0, 8'(i * 29 + 1), "R5");
      tx_step(1'b1, 1'b0, 8'(i * 29 + 1), "R5");
    end
    speed = 2'b11;
    tx_step(1'b0, 1'b0, 8'h00, "R5");
    for (int i = 0; i < 4; i++) begin
      tx_step(1'b1, i[0], 8'(i * 61 + 3), "R5");
      tx_step(1'b1, i[0], 8'(i * 61 + 3), "R5");
    end
    speed = 2'b10;
    tx_step(1'b0, 1'b0, 8'h00, "R5");
    tx_step(1'b0, 1'b0, 8'h00, "R5");

    rx_idle(3);
    for (int i = 0; i < 256; i++) rx_gbyte(8'(i), (i % 7) == 3, "R7");
    rx_idle(2);
    rx_cycle(4'hE, 1'b0, 4'hE, 1'b1, k);
    rx_cycle(4'h7, 1'b0, 4'h7, 1'b1, k);
    rx_idle(2);
    rx_gbyte(8'h11, 1'b0, "R6");
    speed = 2'b01;
    rx_gbyte(8'h22, 1'b1, "R6");
    rx_gbyte(8'h33, 1'b0, "R6");
    rx_idle(2);
    for (int i = 0; i < 256; i++) rx_nbyte(8'(i), i[3], i[4] & i[0], "R9");
    rx_cycle(4'hF, 1'b1, 4'hF, 1'b1, k);
    rx_idle(2);
    rx_nbyte(8'h6B, 1'b0, 1'b0, "R9");
    rx_idle(2);
    speed = 2'b00;
    rx_idle(2);
    for (int i = 0; i < 8; i++) rx_nbyte(8'(i * 53 + 7), 1'b0, i[0], "R5");
    rx_idle(2);
    speed = 2'b11;
    rx_idle(2);
    for (int i = 0; i < 4; i++) rx_nbyte(8'(i * 71 + 9), i[1], 1'b0, "R5");
    rx_idle(2);
    rx_nbyte(8'hA1, 1'b0, 1'b0, "R6");
    speed = 2'b10;
    rx_nbyte(8'hB2, 1'b0, 1'b0, "R6");
    rx_idle(3);
    done = 1'b1;

    check(got_n == exp_n, "R7 R9 strobe count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_v[i] == exp_v[i], {exp_t[i], " byte"}, int'(got_v[i]), int'(exp_v[i]));
      check(got_c[i] == exp_c[i], {exp_t[i], " cycle"}, got_c[i], exp_c[i]);
    end
    summary();
    $finish;
  end
endmodule